// File: doc/BRIEF.md
# Serial Link Status and Service-Request Unit

This block collects the condition of a high-speed serial port into one 8-bit status word. It watches the fill levels of a 16-entry transmit FIFO and a 16-entry receive FIFO. It also scans the tag bits of the lowest eight receive entries and takes single-cycle event strobes from the transmit and receive engines. From these it derives DMA service requests for both directions and one registered interrupt line.

Three of the status bits are sticky error flags. Software clears one by writing a one to its position. The other three bits follow the FIFO state live and cannot be written. The receive DMA request stays off while any end or error tag waits near the bottom of the receive FIFO, so that software can handle the frame boundary first.

Top module: `link_status_unit`

## Requirements
- R1: `reg_rdata` presents the status word with bit 0 as the tag-present flag, bit 1 as underrun, bit 2 as abort, bit 3 as transmit service, bit 4 as receive service and bit 5 as framing error. Bits 7:6 always read zero, and writes to them have no effect. After reset the word reads zero with both engines disabled and no tags present.
- R2: Bits 1, 2 and 5 are sticky. A write with a one in a bit's position clears it. A write with a zero leaves it unchanged. Writes do not affect bits 0, 3 and 4.
- R3: When an event and a clearing write hit the same sticky bit in the same cycle, the bit ends up set.
- R4: Bit 0 is one whenever any bit of `rx_tags` is one. Entry i occupies `rx_tags[3*i+2:3*i]` for i from 0 to 7. While bit 0 is one, `rx_dma_req` is zero, and `irq` is asserted one cycle later regardless of the enables.
- R5: A pulse on `ev_underrun` sets bit 1. Bit 1 drives `irq` only when `ie_underrun` is one.
- R6: Bit 3 and `tx_dma_req` are one exactly when `tx_en` is one and `tx_level` is 8 or less. Bit 3 drives `irq` only when `ie_tx` is one.
- R7: Bit 4 is one exactly when `rx_en` is one and `rx_level` is 12 or more. `rx_dma_req` equals bit 4 gated by the absence of bit 0. Bit 4 drives `irq` only when `ie_rx` is one.
- R8: A pulse on `ev_abort` sets bit 2 and produces a one-cycle `rx_eof_mark` strobe in the following cycle. Bit 2 asserts `irq` without any enable.
- R9: A pulse on `ev_frame_err` sets bit 5, and bit 5 asserts `irq` without any enable.
- R10: `irq` is the registered OR of every active unmaskable or enabled condition. It changes one clock after the status it reflects, and it is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enabled |
| rx_en | input | 1 | Receiver enabled |
| tx_level | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| rx_level | input | 5 | Receive FIFO occupancy, 0 to 16 |
| rx_tags | input | 24 | Tag bits of the bottom eight receive entries, 3 per entry |
| ev_underrun | input | 1 | Transmit fetch from empty FIFO strobe |
| ev_abort | input | 1 | Receive abort strobe (two or more silent chips) |
| ev_frame_err | input | 1 | Preamble followed by an illegal symbol strobe |
| ie_tx | input | 1 | Transmit service interrupt enable |
| ie_rx | input | 1 | Receive service interrupt enable |
| ie_underrun | input | 1 | Underrun interrupt enable |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 8 | Write data, ones clear sticky bits |
| reg_rdata | output | 8 | Current status word |
| tx_dma_req | output | 1 | Transmit DMA service request |
| rx_dma_req | output | 1 | Receive DMA service request |
| rx_eof_mark | output | 1 | Request to tag the last good receive entry as end of frame |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle that a sticky bit never rises without its event and never falls without a clearing write, that a set event always wins, that an abort always yields the end-of-frame strobe, and that the tag-present flag always blocks receive DMA. They also check that the unmaskable flags always lead to an interrupt one cycle later. Only the bench scenarios show the exact threshold edges of both level comparisons and the mapping of each of the 24 tag bits. They likewise show the interaction of the three enables with their sources, and that zero bits and reserved bits in a write leave the word untouched.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
   localparam int unsigned STAT_W  = 8;
   localparam int unsigned POS_EIF = 0;
   localparam int unsigned POS_TUR = 1;
   localparam int unsigned POS_RAB = 2;
   localparam int unsigned POS_TFS = 3;
   localparam int unsigned POS_RFS = 4;
   localparam int unsigned POS_FRE = 5;
   localparam int unsigned N_STICKY = 3;

   typedef struct packed {
      logic [1:0] rsvd;
      logic       frame_err;
      logic       rx_serv;
      logic       tx_serv;
      logic       abort;
      logic       underrun;
      logic       tag_seen;
   } stat_word_t;
endpackage

// File: rtl/lsr_sticky_bit.sv
module lsr_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end

   assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   assert_hold_without_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o && !clr_i) |=> q_o);
   assert_rise_needs_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_o) |-> $past(set_i));
endmodule

// File: rtl/lsr_level_cmp.sv
module lsr_level_cmp #(
   parameter int unsigned LVL_W       = 5,
   parameter int unsigned THRESH      = 8,
   parameter bit          AT_OR_ABOVE = 1'b0
) (
   input  logic             en_i,
   input  logic [LVL_W-1:0] level_i,
   output logic             hit_o
);
   localparam logic [LVL_W-1:0] THR = THRESH[LVL_W-1:0];

   if (THRESH > (2**LVL_W) - 1) begin : g_bad_thresh
      $error("lsr_level_cmp: THRESH does not fit in LVL_W bits");
   end

   if (AT_OR_ABOVE) begin : g_above
      assign hit_o = en_i && (level_i >= THR);
   end else begin : g_below
      assign hit_o = en_i && (level_i <= THR);
   end
endmodule

// File: rtl/lsr_tag_scan.sv
module lsr_tag_scan #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned TAG_W   = 3
) (
   input  logic [ENTRIES*TAG_W-1:0] tags_i,
   output logic                     any_o
);
   logic [ENTRIES-1:0] entry_hit;

   if (ENTRIES < 1 || TAG_W < 1) begin : g_bad_shape
      $error("lsr_tag_scan: ENTRIES and TAG_W must be at least one");
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      assign entry_hit[e] = |tags_i[e*TAG_W +: TAG_W];
   end

   assign any_o = |entry_hit;
endmodule

// File: rtl/link_status_unit.sv
module link_status_unit
   import lsr_pkg::*;
#(
   parameter int unsigned DEPTH        = 16,
   parameter int unsigned TAG_W        = 3,
   parameter int unsigned SCAN_ENTRIES = 8,
   parameter int unsigned TX_THRESH    = 8,
   parameter int unsigned RX_THRESH    = 12,
   localparam int unsigned LVL_W       = $clog2(DEPTH + 1),
   localparam int unsigned TAGS_W      = SCAN_ENTRIES * TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic [LVL_W-1:0]  tx_level,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic [TAGS_W-1:0] rx_tags,
   input  logic              ev_underrun,
   input  logic              ev_abort,
   input  logic              ev_frame_err,
   input  logic              ie_tx,
   input  logic              ie_rx,
   input  logic              ie_underrun,
   input  logic              reg_wr,
   input  logic [STAT_W-1:0] reg_wdata,
   output logic [STAT_W-1:0] reg_rdata,
   output logic              tx_dma_req,
   output logic              rx_dma_req,
   output logic              rx_eof_mark,
   output logic              irq
);
   localparam int unsigned STICKY_POS [N_STICKY] = '{POS_TUR, POS_RAB, POS_FRE};

   if (SCAN_ENTRIES > DEPTH) begin : g_bad_scan
      $error("link_status_unit: scan window exceeds FIFO depth");
   end
   if (TX_THRESH > DEPTH || RX_THRESH > DEPTH) begin : g_bad_thr
      $error("link_status_unit: threshold exceeds FIFO depth");
   end

   stat_word_t          stat;
   logic [N_STICKY-1:0] ev_vec;
   logic [N_STICKY-1:0] sticky_q;
   logic                tag_seen, tx_hit, rx_hit;
   logic                irq_d;
   logic                unused_wdata;

   assign ev_vec = {ev_frame_err, ev_abort, ev_underrun};

   for (genvar s = 0; s < N_STICKY; s++) begin : g_sticky
      lsr_sticky_bit u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (ev_vec[s]),
         .clr_i (reg_wr && reg_wdata[STICKY_POS[s]]),
         .q_o   (sticky_q[s])
      );
   end

   assign unused_wdata = ^{reg_wdata[7:6], reg_wdata[POS_RFS], reg_wdata[POS_TFS],
                           reg_wdata[POS_EIF]};

   lsr_tag_scan #(.ENTRIES(SCAN_ENTRIES), .TAG_W(TAG_W)) u_scan (
      .tags_i (rx_tags),
      .any_o  (tag_seen)
   );

   lsr_level_cmp #(.LVL_W(LVL_W), .THRESH(TX_THRESH), .AT_OR_ABOVE(1'b0)) u_tx_cmp (
      .en_i    (tx_en),
      .level_i (tx_level),
      .hit_o   (tx_hit)
   );

   lsr_level_cmp #(.LVL_W(LVL_W), .THRESH(RX_THRESH), .AT_OR_ABOVE(1'b1)) u_rx_cmp (
      .en_i    (rx_en),
      .level_i (rx_level),
      .hit_o   (rx_hit)
   );

   always_comb begin
      stat           = '0;
      stat.tag_seen  = tag_seen;
      stat.underrun  = sticky_q[0];
      stat.abort     = sticky_q[1];
      stat.tx_serv   = tx_hit;
      stat.rx_serv   = rx_hit;
      stat.frame_err = sticky_q[2];
   end

   assign reg_rdata  = stat;
   assign tx_dma_req = stat.tx_serv;
   assign rx_dma_req = stat.rx_serv && !stat.tag_seen;

   assign irq_d = stat.tag_seen | stat.abort | stat.frame_err
                | (stat.underrun & ie_underrun)
                | (stat.tx_serv  & ie_tx)
                | (stat.rx_serv  & ie_rx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq         <= 1'b0;
         rx_eof_mark <= 1'b0;
      end else begin
         irq         <= irq_d;
         rx_eof_mark <= ev_abort;
      end
   end

   assert_rxdma_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dma_req |-> !reg_rdata[POS_EIF]);
   assert_tag_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[POS_EIF] |=> irq);
   assert_txdma_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_dma_req |-> tx_en);
   assert_rxdma_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dma_req |-> rx_en);
   assert_abort_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_abort |=> (rx_eof_mark && reg_rdata[POS_RAB]));
   assert_frame_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[POS_FRE] |=> irq);
   assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(|reg_rdata[5:0]));
endmodule

// File: tb/test_link_status_unit.sv
`timescale 1ns/1ps
module test_link_status_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_en = 0, rx_en = 0;
   logic [4:0]  tx_level = 0, rx_level = 0;
   logic [23:0] rx_tags = 0;
   logic        ev_underrun = 0, ev_abort = 0, ev_frame_err = 0;
   logic        ie_tx = 0, ie_rx = 0, ie_underrun = 0;
   logic        reg_wr = 0;
   logic [7:0]  reg_wdata = 0;
   logic [7:0]  reg_rdata;
   logic        tx_dma_req, rx_dma_req, rx_eof_mark, irq;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   link_status_unit i_link_status_unit (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
      .tx_level(tx_level), .rx_level(rx_level), .rx_tags(rx_tags),
      .ev_underrun(ev_underrun), .ev_abort(ev_abort), .ev_frame_err(ev_frame_err),
      .ie_tx(ie_tx), .ie_rx(ie_rx), .ie_underrun(ie_underrun),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
      .rx_eof_mark(rx_eof_mark), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic clear_all();
      reg_wr = 1; reg_wdata = 8'hFF;
      tick();
      reg_wr = 0; reg_wdata = 8'h00;
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset word", {24'd0, reg_rdata}, 32'h00);
      chk("R10 reset irq", {31'd0, irq}, 0);
      rst_n = 1;
      tick();
      chk("R1 idle word", {24'd0, reg_rdata}, 32'h00);

      // R6 transmit threshold sweep
      for (int en = 0; en < 2; en++) begin
         for (int lv = 0; lv <= 16; lv++) begin
            tx_en = en[0]; tx_level = lv[4:0];
            settle();
            chk("R6 tx service bit", {31'd0, reg_rdata[3]}, {31'd0, (en == 1 && lv <= 8)});
            chk("R6 tx dma", {31'd0, tx_dma_req}, {31'd0, (en == 1 && lv <= 8)});
         end
      end
      tx_en = 0; tx_level = 0;

      // R7 receive threshold sweep
      for (int en = 0; en < 2; en++) begin
         for (int lv = 0; lv <= 16; lv++) begin
            rx_en = en[0]; rx_level = lv[4:0];
            settle();
            chk("R7 rx service bit", {31'd0, reg_rdata[4]}, {31'd0, (en == 1 && lv >= 12)});
            chk("R7 rx dma", {31'd0, rx_dma_req}, {31'd0, (en == 1 && lv >= 12)});
         end
      end

      // R4 each tag bit individually, receiver requesting
      rx_en = 1; rx_level = 5'd16;
      for (int b = 0; b < 24; b++) begin
         rx_tags = 24'd1 << b;
         settle();
         chk("R4 tag flag", {31'd0, reg_rdata[0]}, 1);
         chk("R4 rx dma blocked", {31'd0, rx_dma_req}, 0);
         chk("R7 rx service stays", {31'd0, reg_rdata[4]}, 1);
      end
      rx_tags = 0;
      settle();
      chk("R4 no tags", {31'd0, reg_rdata[0]}, 0);
      chk("R7 rx dma restored", {31'd0, rx_dma_req}, 1);
      // R4 tag irq even with all enables off
      rx_en = 0; rx_level = 0; rx_tags = 24'h800000;
      tick();
      chk("R4 tag irq unmasked", {31'd0, irq}, 1);
      rx_tags = 0;
      tick();
      tick();
      chk("R10 irq drops", {31'd0, irq}, 0);

      // R10 service interrupt enables sweep
      for (int k = 0; k < 16; k++) begin
         tx_en = k[0]; tx_level = 0;
         rx_en = k[1]; rx_level = 5'd16;
         ie_tx = k[2]; ie_rx = k[3];
         tick();
         chk("R10 service irq", {31'd0, irq}, {31'd0, (k[0] & k[2]) | (k[1] & k[3])});
      end
      tx_en = 0; rx_en = 0; rx_level = 0; ie_tx = 0; ie_rx = 0;
      tick();

      // R5 underrun, masked then enabled
      ev_underrun = 1;
      tick();
      ev_underrun = 0;
      chk("R5 underrun set", {24'd0, reg_rdata}, 32'h02);
      tick();
      chk("R5 underrun masked", {31'd0, irq}, 0);
      ie_underrun = 1;
      tick();
      chk("R5 underrun enabled irq", {31'd0, irq}, 1);
      ie_underrun = 0;

      // R2 zero write keeps, reserved write ignored, one clears
      reg_wr = 1; reg_wdata = 8'hC0;
      tick();
      reg_wr = 0;
      chk("R2 zero write keeps", {24'd0, reg_rdata}, 32'h02);
      chk("R1 reserved reads zero", {30'd0, reg_rdata[7:6]}, 0);
      reg_wr = 1; reg_wdata = 8'h02;
      tick();
      reg_wr = 0;
      chk("R2 one clears", {24'd0, reg_rdata}, 32'h00);

      // R3 set wins over clear on each sticky bit
      ev_underrun = 1; ev_abort = 1; ev_frame_err = 1;
      reg_wr = 1; reg_wdata = 8'hFF;
      tick();
      ev_underrun = 0; ev_abort = 0; ev_frame_err = 0; reg_wr = 0;
      chk("R3 set wins", {24'd0, reg_rdata}, 32'h26);
      // R2 clear selectively: only frame error
      reg_wr = 1; reg_wdata = 8'h20;
      tick();
      reg_wr = 0;
      chk("R2 selective clear", {24'd0, reg_rdata}, 32'h06);
      clear_all();
      chk("R2 all cleared", {24'd0, reg_rdata}, 32'h00);
      tick();

      // R8 abort: strobe, sticky bit, unmasked irq
      ev_abort = 1;
      tick();
      ev_abort = 0;
      chk("R8 abort bit", {24'd0, reg_rdata}, 32'h04);
      chk("R8 eof strobe", {31'd0, rx_eof_mark}, 1);
      tick();
      chk("R8 eof one cycle", {31'd0, rx_eof_mark}, 0);
      chk("R8 abort irq", {31'd0, irq}, 1);
      clear_all();
      tick();
      chk("R10 irq after clear", {31'd0, irq}, 0);

      // R9 framing error, unmaskable
      ev_frame_err = 1;
      tick();
      ev_frame_err = 0;
      chk("R9 frame bit", {24'd0, reg_rdata}, 32'h20);
      chk("R10 irq lags status", {31'd0, irq}, 0);
      tick();
      chk("R9 frame irq", {31'd0, irq}, 1);
      clear_all();

      // R1 full word with live bits
      tx_en = 1; tx_level = 5'd8; rx_en = 1; rx_level = 5'd12; rx_tags = 24'h000008;
      ev_underrun = 1;
      tick();
      ev_underrun = 0;
      chk("R1 combined word", {24'd0, reg_rdata}, 32'h1B);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule